// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block sits beside a processor core and answers its coprocessor register-transfer commands. Each command is a one-cycle strobe. It carries a direction, a primary register number, a secondary register field, two opcode fields, the privilege level of the core, the index of the core register involved, and write data. The block decodes the command and then does one of three things: it returns read data, it updates its control state, or it signals an undefined-instruction trap.

The block holds three kinds of register. Two of them are fixed, read-only words: an identification word and a cache description word, both set by parameters. The third is a control register whose defined bits drive three outputs to the memory system: translation enable, byte-order select and exception-vector-base select. When the core names register index 15 as the destination of a read, the top four bits of the read value go to the condition-flag update path instead of the general register write port.

Top module: `sysctl_cop`

## Requirements
- R1: While reset is held, the control register clears to zero, except the vector-base bit (bit 13), which copies `vec_hi_strap_i`. After reset, `mmu_en_o` and `big_endian_o` are 0, `hivec_o` equals the strap level, and all three result strobes are low.
- R2: A privileged read (`is_read_i`=1) of register 0 returns the `CACHE_TYPE` parameter when `op2_i`=1, and the `ID_CODE` parameter for any other `op2_i`. Fields `crm_i` and `op1_i` have no effect on this read.
- R3: A privileged write (`is_read_i`=0) to register 1 with `crm_i`, `op1_i` and `op2_i` all zero loads bits 0, 7 and 13 from `wdata_i` at the clock edge that samples the strobe. From then on, `mmu_en_o` = bit 0, `big_endian_o` = bit 7 (1 = big-endian) and `hivec_o` = bit 13.
- R4: A privileged read of register 1 with `crm_i`, `op1_i` and `op2_i` zero returns the three defined bits in their positions (0, 7, 13), with every other bit 0.
- R5: A request with `priv_i`=0, read or write, raises `undef_o` for one cycle, one cycle after the strobe. It raises neither read strobe and changes no control state.
- R6: Read results appear one cycle after the strobe. If `dest_idx_i` is not 15, `reg_we_o` pulses and `rdata_o` holds the value. If `dest_idx_i` is 15, `flags_we_o` pulses instead, and `flags_o` carries bits 31..28 of the value.
- R7: Writes to register 0 and to register numbers 2 to 15 change no state. Privileged reads of register numbers 2 to 15 return 0.
- R8: A register-1 access with a nonzero `crm_i`, `op1_i` or `op2_i` is treated as an unimplemented register. A write of this kind is ignored, and a read of this kind returns 0.
- R9: At most one of `reg_we_o`, `flags_we_o` and `undef_o` is high in any cycle, and a privileged write raises none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| vec_hi_strap_i | input | 1 | Reset level of the vector-base control bit |
| req_i | input | 1 | Command strobe, one cycle per command |
| is_read_i | input | 1 | 1 = coprocessor-to-core read, 0 = core-to-coprocessor write |
| crn_i | input | 4 | Primary register number |
| crm_i | input | 4 | Secondary register field |
| op1_i | input | 3 | First opcode field |
| op2_i | input | 3 | Second opcode field |
| priv_i | input | 1 | 1 = core is in a privileged mode |
| dest_idx_i | input | 4 | Core register index targeted by a read |
| wdata_i | input | 32 | Write data |
| reg_we_o | output | 1 | Read result valid for the general register port |
| rdata_o | output | 32 | Read result |
| flags_we_o | output | 1 | Read result goes to the condition flags |
| flags_o | output | 4 | Flag values (N, Z, C, V order from MSB) |
| undef_o | output | 1 | Undefined-instruction trap pulse |
| mmu_en_o | output | 1 | Address translation enable |
| big_endian_o | output | 1 | Byte-order select, 1 = big-endian |
| hivec_o | output | 1 | Exception vector base select |

## Verification
Register 0 is read with `op2_i` set to 0, 1 and 5, which shows that only the value 1 picks the cache word. The control register gets an all-ones write and then a single-bit write, which shows that the reserved bits are dropped and that each output follows its own bit. The same commands are sent again with `priv_i` low, with a destination index of 15, with nonzero sub-fields, and to register 0 and unimplemented numbers. These runs separate the trap, the flag route and the ignored write from a normal access. Reset is applied with both strap levels.

// File: rtl/sysctl_cop_pkg.sv
package sysctl_cop_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned REG_W  = 4;
    localparam int unsigned OP_W   = 3;

    // bit positions of the control register that hold state
    localparam int unsigned BIT_MMU   = 0;
    localparam int unsigned BIT_BEND  = 7;
    localparam int unsigned BIT_HIVEC = 13;

    localparam logic [REG_W-1:0] FLAGS_DEST = 4'd15;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_ID,
        TGT_CTYPE,
        TGT_CTRL
    } cop_tgt_e;

    typedef struct packed {
        logic        rd;
        logic        wr_ctrl;
        logic        trap;
        logic        to_flags;
        cop_tgt_e    tgt;
    } cop_dec_t;

    typedef struct packed {
        logic              reg_we;
        logic              flags_we;
        logic              undef;
        logic [WORD_W-1:0] rdata;
    } cop_rsp_t;

endpackage

// File: rtl/sysctl_cop_decode.sv
module sysctl_cop_decode
    import sysctl_cop_pkg::*;
(
    input  logic             req_i,
    input  logic             is_read_i,
    input  logic [REG_W-1:0] crn_i,
    input  logic [REG_W-1:0] crm_i,
    input  logic [OP_W-1:0]  op1_i,
    input  logic [OP_W-1:0]  op2_i,
    input  logic             priv_i,
    input  logic [REG_W-1:0] dest_idx_i,
    output cop_dec_t         dec_o
);

    logic ok;
    logic ctrl_sel;

    always_comb begin
        ok       = req_i && priv_i;
        ctrl_sel = (crn_i == REG_W'(1)) && (crm_i == '0)
                   && (op1_i == '0) && (op2_i == '0);

        dec_o          = '0;
        dec_o.tgt      = TGT_NONE;
        if (crn_i == '0) begin
            dec_o.tgt = (op2_i == OP_W'(1)) ? TGT_CTYPE : TGT_ID;
        end else if (ctrl_sel) begin
            dec_o.tgt = TGT_CTRL;
        end
        dec_o.trap     = req_i && !priv_i;
        dec_o.rd       = ok && is_read_i;
        dec_o.wr_ctrl  = ok && !is_read_i && (dec_o.tgt == TGT_CTRL);
        dec_o.to_flags = dest_idx_i == FLAGS_DEST;
    end

endmodule

// File: rtl/sysctl_cop_ctrlreg.sv
module sysctl_cop_ctrlreg
    import sysctl_cop_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              vec_hi_strap_i,
    input  logic              we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] ctrl_o
);

    localparam logic [WORD_W-1:0] DEF_MASK =
        (WORD_W'(1) << BIT_MMU) | (WORD_W'(1) << BIT_BEND) | (WORD_W'(1) << BIT_HIVEC);

    logic [WORD_W-1:0] ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (we_i) begin
            ctrl_d = wdata_i & DEF_MASK;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q            <= '0;
            ctrl_q[BIT_HIVEC] <= vec_hi_strap_i;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl_o = ctrl_q;

    // R3
    hold_without_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(ctrl_q));

    // R4
    reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> ((ctrl_q & ~DEF_MASK) == '0));

endmodule

// File: rtl/sysctl_cop_rdpath.sv
module sysctl_cop_rdpath
    import sysctl_cop_pkg::*;
#(
    parameter logic [WORD_W-1:0] ID_CODE    = 32'hA5C0_0013,
    parameter logic [WORD_W-1:0] CACHE_TYPE = 32'h0D17_2192
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  cop_dec_t          dec_i,
    input  logic [WORD_W-1:0] ctrl_i,
    output cop_rsp_t          rsp_o
);

    cop_rsp_t          rsp_d, rsp_q;
    logic [WORD_W-1:0] sel_word;

    always_comb begin
        unique case (dec_i.tgt)
            TGT_ID:    sel_word = ID_CODE;
            TGT_CTYPE: sel_word = CACHE_TYPE;
            TGT_CTRL:  sel_word = ctrl_i;
            default:   sel_word = '0;
        endcase

        rsp_d          = rsp_q;
        rsp_d.reg_we   = dec_i.rd && !dec_i.to_flags;
        rsp_d.flags_we = dec_i.rd && dec_i.to_flags;
        rsp_d.undef    = dec_i.trap;
        if (dec_i.rd) begin
            rsp_d.rdata = sel_word;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_o = rsp_q;

    // R9
    one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rsp_q.reg_we, rsp_q.flags_we, rsp_q.undef}));

    // R2
    ctype_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_i.rd && dec_i.tgt == TGT_CTYPE) |=> (rsp_q.rdata == CACHE_TYPE));

endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
    import sysctl_cop_pkg::*;
#(
    parameter logic [31:0] ID_CODE    = 32'hA5C0_0013,
    parameter logic [31:0] CACHE_TYPE = 32'h0D17_2192
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        vec_hi_strap_i,
    input  logic        req_i,
    input  logic        is_read_i,
    input  logic [3:0]  crn_i,
    input  logic [3:0]  crm_i,
    input  logic [2:0]  op1_i,
    input  logic [2:0]  op2_i,
    input  logic        priv_i,
    input  logic [3:0]  dest_idx_i,
    input  logic [31:0] wdata_i,
    output logic        reg_we_o,
    output logic [31:0] rdata_o,
    output logic        flags_we_o,
    output logic [3:0]  flags_o,
    output logic        undef_o,
    output logic        mmu_en_o,
    output logic        big_endian_o,
    output logic        hivec_o
);

    cop_dec_t          dec;
    cop_rsp_t          rsp;
    logic [WORD_W-1:0] ctrl;

    sysctl_cop_decode u_decode (
        .req_i      (req_i),
        .is_read_i  (is_read_i),
        .crn_i      (crn_i),
        .crm_i      (crm_i),
        .op1_i      (op1_i),
        .op2_i      (op2_i),
        .priv_i     (priv_i),
        .dest_idx_i (dest_idx_i),
        .dec_o      (dec)
    );

    sysctl_cop_ctrlreg u_ctrlreg (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .vec_hi_strap_i (vec_hi_strap_i),
        .we_i           (dec.wr_ctrl),
        .wdata_i        (wdata_i),
        .ctrl_o         (ctrl)
    );

    sysctl_cop_rdpath #(
        .ID_CODE    (ID_CODE),
        .CACHE_TYPE (CACHE_TYPE)
    ) u_rdpath (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .dec_i  (dec),
        .ctrl_i (ctrl),
        .rsp_o  (rsp)
    );

    assign reg_we_o     = rsp.reg_we;
    assign rdata_o      = rsp.rdata;
    assign flags_we_o   = rsp.flags_we;
    assign flags_o      = rsp.rdata[WORD_W-1 -: 4];
    assign undef_o      = rsp.undef;
    assign mmu_en_o     = ctrl[BIT_MMU];
    assign big_endian_o = ctrl[BIT_BEND];
    assign hivec_o      = ctrl[BIT_HIVEC];

    // R5
    user_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !priv_i) |=> (undef_o && !reg_we_o && !flags_we_o));

    // R5
    user_no_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !priv_i) |=> ($stable(mmu_en_o) && $stable(big_endian_o) && $stable(hivec_o)));

    // R6
    flags_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && priv_i && is_read_i && dest_idx_i == 4'd15) |=> (flags_we_o && !reg_we_o));

    // R9
    write_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && priv_i && !is_read_i) |=> (!reg_we_o && !flags_we_o && !undef_o));

endmodule

// File: tb/sysctl_cop_bench.sv
`timescale 1ns/1ps
module sysctl_cop_bench;

    localparam logic [31:0] IDC = 32'hA5C0_0013;
    localparam logic [31:0] CTC = 32'h0D17_2192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        req = 1'b0;
    logic        is_read = 1'b0;
    logic [3:0]  crn = '0, crm = '0, dest = '0;
    logic [2:0]  op1 = '0, op2 = '0;
    logic        priv = 1'b0;
    logic [31:0] wdata = '0;
    logic        reg_we, flags_we, undef, mmu_en, bend, hivec;
    logic [31:0] rdata;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 register port, 1 flags, 2 trap
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    sysctl_cop #(.ID_CODE(IDC), .CACHE_TYPE(CTC)) u_sysctl_cop (
        .clk_i(clk), .rst_ni(rst_n), .vec_hi_strap_i(strap),
        .req_i(req), .is_read_i(is_read), .crn_i(crn), .crm_i(crm),
        .op1_i(op1), .op2_i(op2), .priv_i(priv), .dest_idx_i(dest),
        .wdata_i(wdata), .reg_we_o(reg_we), .rdata_o(rdata),
        .flags_we_o(flags_we), .flags_o(flags), .undef_o(undef),
        .mmu_en_o(mmu_en), .big_endian_o(bend), .hivec_o(hivec)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per result strobe
    always @(negedge clk) begin
        if (rst_n && (reg_we || flags_we || undef)) begin
            if (sb.size() == 0) begin
                check("R9 unexpected strobe", {29'd0, reg_we, flags_we, undef}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " strobe"}, {29'd0, reg_we, flags_we, undef},
                      (e.kind == 0) ? 32'd4 : (e.kind == 1) ? 32'd2 : 32'd1);
                if (e.kind == 0) check({e.tag, " rdata"}, rdata, e.data);
                if (e.kind == 1) check({e.tag, " flags"}, {28'd0, flags}, {28'd0, e.data[31:28]});
            end
        end
    end

    task automatic issue(bit rd, logic [3:0] n, logic [3:0] m, logic [2:0] o1,
                         logic [2:0] o2, bit pv, logic [3:0] d, logic [31:0] wd,
                         logic [31:0] expv, string tag);
        @(negedge clk);
        req = 1'b1; is_read = rd; crn = n; crm = m; op1 = o1; op2 = o2;
        priv = pv; dest = d; wdata = wd;
        if (!pv) sb.push_back('{2, 32'd0, tag});
        else if (rd) sb.push_back('{(d == 4'd15) ? 1 : 0, expv, tag});
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic do_reset(bit s);
        @(negedge clk);
        rst_n = 1'b0; strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_ctrl(string tag, bit m, bit b, bit h);
        check(tag, {29'd0, mmu_en, bend, hivec}, {29'd0, m, b, h});
    endtask

    initial begin
        do_reset(1'b0);
        // R1 reset state, strap low
        check_ctrl("R1 outputs after reset", 0, 0, 0);
        check("R1 strobes after reset", {29'd0, reg_we, flags_we, undef}, 32'd0);

        // R2 register 0 selection
        issue(1, 0, 0, 0, 0, 1, 3, 0, IDC, "R2 id op2=0");
        issue(1, 0, 0, 0, 1, 1, 3, 0, CTC, "R2 cache op2=1");
        issue(1, 0, 0, 0, 5, 1, 3, 0, IDC, "R2 id op2=5");
        issue(1, 0, 2, 3, 1, 1, 3, 0, CTC, "R2 cache crm/op1 ignored");
        // R4 control reset value
        issue(1, 1, 0, 0, 0, 1, 2, 0, 32'd0, "R4 ctrl reset read");

        // R3 full write, R4 readback
        issue(0, 1, 0, 0, 0, 1, 0, 32'hFFFF_FFFF, 0, "R3 write ones");
        check_ctrl("R3 outputs after ones", 1, 1, 1);
        issue(1, 1, 0, 0, 0, 1, 2, 0, 32'h0000_2081, "R4 ctrl readback");
        issue(0, 1, 0, 0, 0, 1, 0, 32'h0000_0080, 0, "R3 write bend");
        check_ctrl("R3 outputs after bend", 0, 1, 0);

        // R5 unprivileged accesses
        issue(0, 1, 0, 0, 0, 0, 0, 32'h0000_2001, 0, "R5 user write");
        check_ctrl("R5 state after user write", 0, 1, 0);
        issue(1, 0, 0, 0, 0, 0, 4, 0, 0, "R5 user read");

        // R6 flags route
        issue(1, 0, 0, 0, 0, 1, 15, 0, IDC, "R6 id to flags");
        issue(1, 0, 0, 0, 1, 1, 15, 0, CTC, "R6 cache to flags");

        // R7 ignored writes, unimplemented reads
        issue(0, 0, 0, 0, 0, 1, 0, 32'h0000_0001, 0, "R7 write reg0");
        issue(0, 7, 0, 0, 0, 1, 0, 32'h0000_2001, 0, "R7 write reg7");
        check_ctrl("R7 state after ignored writes", 0, 1, 0);
        issue(1, 0, 0, 0, 0, 1, 1, 0, IDC, "R7 reg0 unchanged");
        issue(1, 5, 0, 0, 0, 1, 1, 0, 32'd0, "R7 read reg5");
        issue(1, 4'hF, 0, 0, 0, 1, 1, 0, 32'd0, "R7 read reg15");

        // R8 register 1 with nonzero sub-fields
        issue(0, 1, 1, 0, 0, 1, 0, 32'h0000_0001, 0, "R8 write crm=1");
        issue(0, 1, 0, 2, 0, 1, 0, 32'h0000_2000, 0, "R8 write op1=2");
        check_ctrl("R8 state after odd writes", 0, 1, 0);
        issue(1, 1, 0, 0, 1, 1, 1, 0, 32'd0, "R8 read op2=1");
        issue(1, 1, 0, 0, 0, 1, 1, 0, 32'h0000_0080, "R8 ctrl intact");

        // R1 strap high
        do_reset(1'b1);
        check_ctrl("R1 outputs strap high", 0, 0, 1);
        issue(1, 1, 0, 0, 0, 1, 2, 0, 32'h0000_2000, "R1 ctrl strap high");

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", sb.size(), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule